// File: doc/BRIEF.md
# Register-Mapped AXI4-Lite Master Bridge

This block lets a host with a 16-bit register bus run single 32-bit transfers on an AXI4-Lite master port. The host writes the target address and the write data as two 16-bit halves each. It then writes a command code into the control register. The bridge runs one AXI4-Lite read or write. It stores returned read data in two 16-bit read registers, and it reports how the transfer ended through sticky event bits in a status register.

There are three outcomes: completion, error response and timeout. An external interrupt line adds a fourth event. Each event can be enabled on its own. A single level interrupt output is high while any enabled event is pending. Two of the command codes add 4 to the stored address after a successful transfer, so the host can walk through consecutive words without reloading the address.

Top module: `axb_bridge`

## Requirements
- R1: Host register index 0 is status, 1 control, 2 and 3 address low/high, 4 and 5 write data low/high, 6 and 7 read data low/high. A 32-bit value is the high register shifted left by 16, ORed with the low register. Control reads back its event enables in bits 15..11 and zeros below.
- R2: After reset every register reads zero. Status bit 5 (initialisation done) becomes 1 exactly INIT_CYCLES clock edges after reset is released.
- R3: A write to control while idle starts a transfer when its low nibble is 0x8 (write), 0x9 (write, then increment), 0xA (read) or 0xB (read, then increment). Any other nibble starts nothing.
- R4: Status bit 6 (busy) is 1 from the edge that accepts a command until the edge that ends the transfer. While busy, new commands are ignored and so are writes to registers 2..5.
- R5: A write transfer presents the address registers on AW and the write-data registers on W, with strobe 0xF and protection 0. It makes exactly one AW handshake and one W handshake. AWVALID holds until it is accepted.
- R6: A read transfer issues one AR handshake. An OKAY read stores RDATA in registers 6/7 and sets status bit 7 (read data available). Bit 7 clears when the next transfer starts.
- R7: Each transfer ends in exactly one event. A response with bit 1 clear sets read complete (bit 15) or write complete (bit 14). A response with bit 1 set (SLVERR, DECERR) sets error (bit 12).
- R8: If no response arrives within TIMEOUT cycles of the start, timeout (bit 13) is set, the channel valids drop and busy clears. Busy lasts exactly TIMEOUT cycles.
- R9: Commands 0x9 and 0xB add 4 to the 32-bit address, with the carry crossing the two halves, only when the transfer completes without error.
- R10: Event bits 15..11 set only if the control enable at the same position is 1. They stay set until the host writes 1 to them in the status register. When an event and a clear land on the same edge, the bit ends up set.
- R11: Status bit 11 is set on any edge where the external interrupt input is high and its enable is 1.
- R12: The interrupt output is 1 exactly when some event bit and its enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register index |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Register read data (combinational on host_addr) |
| xirq_i | input | 1 | External interrupt event source |
| irq_o | output | 1 | Level interrupt |
| m_axi_awaddr | output | 32 | Write address |
| m_axi_awprot | output | 3 | Write protection |
| m_axi_awvalid | output | 1 | Write address valid |
| m_axi_awready | input | 1 | Write address ready |
| m_axi_wdata | output | 32 | Write data |
| m_axi_wstrb | output | 4 | Write strobes |
| m_axi_wvalid | output | 1 | Write data valid |
| m_axi_wready | input | 1 | Write data ready |
| m_axi_bresp | input | 2 | Write response |
| m_axi_bvalid | input | 1 | Write response valid |
| m_axi_bready | output | 1 | Write response ready |
| m_axi_araddr | output | 32 | Read address |
| m_axi_arprot | output | 3 | Read protection |
| m_axi_arvalid | output | 1 | Read address valid |
| m_axi_arready | input | 1 | Read address ready |
| m_axi_rdata | input | 32 | Read data |
| m_axi_rresp | input | 2 | Read response |
| m_axi_rvalid | input | 1 | Read data valid |
| m_axi_rready | output | 1 | Read data ready |

## Verification
The assertions check on every cycle that a transfer has at most one outcome and that address valids hold until accepted. They also check that read and write channels never run together, that event bits stay set and stay off while disabled, that the address is frozen during a transfer except for the post-increment step, and that the timeout counter stays in range. Only the bench's scenarios can show the end-to-end behaviour. That covers the exact address and data seen by the slave, the carry across the address halves, the exact length of a timeout, a command being ignored while busy, and the set-over-clear priority with the interrupt input held high. Each of these is compared against a cycle-level reference model.

// File: rtl/axb_pkg.sv
package axb_pkg;
  localparam int HOST_W = 16;
  localparam int BUS_W  = 2 * HOST_W;
  localparam int NEV    = 5;

  // host register indices (software decodes these)
  localparam logic [2:0] RI_STAT = 3'd0;
  localparam logic [2:0] RI_CTL  = 3'd1;
  localparam logic [2:0] RI_ADL  = 3'd2;
  localparam logic [2:0] RI_ADH  = 3'd3;
  localparam logic [2:0] RI_WDL  = 3'd4;
  localparam logic [2:0] RI_WDH  = 3'd5;
  localparam logic [2:0] RI_RDL  = 3'd6;
  localparam logic [2:0] RI_RDH  = 3'd7;

  // status bit positions; event i lives at EV_LO + i
  localparam int EV_LO     = 11;
  localparam int SB_RAVAIL = 7;
  localparam int SB_BUSY   = 6;
  localparam int SB_INIT   = 5;

  // event order inside the 5-bit vector
  localparam int EVI_XIRQ = 0;
  localparam int EVI_ERR  = 1;
  localparam int EVI_TMO  = 2;
  localparam int EVI_WOK  = 3;
  localparam int EVI_ROK  = 4;

  function automatic logic cmd_valid(input logic [3:0] c);
    return c[3:2] == 2'b10;
  endfunction

  function automatic logic cmd_is_read(input logic [3:0] c);
    return c[1];
  endfunction

  function automatic logic cmd_incr(input logic [3:0] c);
    return c[0];
  endfunction

  function automatic logic resp_bad(input logic [1:0] r);
    return r[1];
  endfunction

  function automatic logic [BUS_W-1:0] bump_addr(input logic [BUS_W-1:0] a);
    return a + BUS_W'(4);
  endfunction
endpackage

// File: rtl/axb_xfer.sv
module axb_xfer #(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int TIMEOUT = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_rd,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [AW-1:0] awaddr,
  output logic          awvalid,
  input  logic          awready,
  output logic [DW-1:0] wdata,
  output logic          wvalid,
  input  logic          wready,
  input  logic [1:0]    bresp,
  input  logic          bvalid,
  output logic          bready,
  output logic [AW-1:0] araddr,
  output logic          arvalid,
  input  logic          arready,
  input  logic [1:0]    rresp,
  input  logic          rvalid,
  output logic          rready,
  output logic          busy,
  output logic          ev_rok,
  output logic          ev_wok,
  output logic          ev_err,
  output logic          ev_tmo
);
  import axb_pkg::*;

  localparam int CW = $clog2(TIMEOUT + 1);

  typedef enum logic [2:0] {S_IDLE, S_WADDR, S_WRESP, S_RADDR, S_RDATA} st_t;

  st_t           st_q;
  logic [CW-1:0] cnt_q;
  logic          awv_q, wv_q, arv_q;

  logic aw_hs, w_hs, ar_hs, resp_hs, aw_left, w_left;
  logic [1:0] resp_code;

  assign awaddr  = addr_i;
  assign araddr  = addr_i;
  assign wdata   = wdata_i;
  assign awvalid = awv_q;
  assign wvalid  = wv_q;
  assign arvalid = arv_q;
  assign bready  = (st_q == S_WRESP);
  assign rready  = (st_q == S_RDATA);
  assign busy    = (st_q != S_IDLE);

  assign aw_hs   = awv_q & awready;
  assign w_hs    = wv_q & wready;
  assign ar_hs   = arv_q & arready;
  assign aw_left = awv_q & ~aw_hs;
  assign w_left  = wv_q & ~w_hs;

  assign resp_hs   = (bready & bvalid) | (rready & rvalid);
  assign resp_code = rready ? rresp : bresp;

  assign ev_rok = resp_hs & rready & ~resp_bad(resp_code);
  assign ev_wok = resp_hs & bready & ~resp_bad(resp_code);
  assign ev_err = resp_hs & resp_bad(resp_code);
  assign ev_tmo = busy & ~resp_hs & (cnt_q == CW'(TIMEOUT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      awv_q <= 1'b0;
      wv_q  <= 1'b0;
      arv_q <= 1'b0;
    end else if (st_q == S_IDLE) begin
      if (start) begin
        cnt_q <= '0;
        if (start_rd) begin
          arv_q <= 1'b1;
          st_q  <= S_RADDR;
        end else begin
          awv_q <= 1'b1;
          wv_q  <= 1'b1;
          st_q  <= S_WADDR;
        end
      end
    end else if (ev_tmo) begin
      st_q  <= S_IDLE;
      awv_q <= 1'b0;
      wv_q  <= 1'b0;
      arv_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
      case (st_q)
        S_WADDR: begin
          if (aw_hs) awv_q <= 1'b0;
          if (w_hs)  wv_q  <= 1'b0;
          if (!aw_left && !w_left) st_q <= S_WRESP;
        end
        S_WRESP: if (bvalid) st_q <= S_IDLE;
        S_RADDR: if (ar_hs) begin
          arv_q <= 1'b0;
          st_q  <= S_RDATA;
        end
        S_RDATA: if (rvalid) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_rok, ev_wok, ev_err, ev_tmo})); // R7
  AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && !awready && !ev_tmo) |=> awvalid); // R5
  AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (arvalid && !arready && !ev_tmo) |=> arvalid); // R6
  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    !(arvalid && (awvalid || wvalid))); // R4
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rok || ev_wok || ev_err || ev_tmo) |=> !busy); // R4
  AST_TMO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q < CW'(TIMEOUT))); // R8
endmodule

// File: rtl/axb_events.sv
module axb_events #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] st_o,
  output logic         irq_o
);
  logic [N-1:0] st_q;

  for (genvar i = 0; i < N; i++) begin : g_ev
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    st_q[i] <= 1'b0;
      else if (set_i[i] && en_i[i])  st_q[i] <= 1'b1;
      else if (clr_i[i])             st_q[i] <= 1'b0;
    end

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[i] && !clr_i[i]) |=> st_q[i]); // R10
    AST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_q[i] && !en_i[i]) |=> !st_q[i]); // R10
  end

  assign st_o  = st_q;
  assign irq_o = |(st_q & en_i);
endmodule

// File: rtl/axb_bridge.sv
module axb_bridge #(
  parameter int TIMEOUT     = 256,
  parameter int INIT_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [2:0]  host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  input  logic        xirq_i,
  output logic        irq_o,
  output logic [31:0] m_axi_awaddr,
  output logic [2:0]  m_axi_awprot,
  output logic        m_axi_awvalid,
  input  logic        m_axi_awready,
  output logic [31:0] m_axi_wdata,
  output logic [3:0]  m_axi_wstrb,
  output logic        m_axi_wvalid,
  input  logic        m_axi_wready,
  input  logic [1:0]  m_axi_bresp,
  input  logic        m_axi_bvalid,
  output logic        m_axi_bready,
  output logic [31:0] m_axi_araddr,
  output logic [2:0]  m_axi_arprot,
  output logic        m_axi_arvalid,
  input  logic        m_axi_arready,
  input  logic [31:0] m_axi_rdata,
  input  logic [1:0]  m_axi_rresp,
  input  logic        m_axi_rvalid,
  output logic        m_axi_rready
);
  import axb_pkg::*;

  localparam int IW = $clog2(INIT_CYCLES + 1);

  logic [NEV-1:0]    en_q, ev_set, ev_clr, ev_st;
  logic [BUS_W-1:0]  addr_q, wd_q, rd_q;
  logic              inc_q, ravail_q, init_q;
  logic [IW-1:0]     init_cnt;
  logic              busy, ev_rok, ev_wok, ev_err, ev_tmo;
  logic              wr_stat, wr_ctl, start, inc_fire, reg_open;
  logic [3:0]        cmd;
  logic [HOST_W-1:0] stat_w;

  // named internal events
  assign cmd      = host_wdata[3:0];
  assign wr_stat  = host_we && (host_addr == RI_STAT);
  assign wr_ctl   = host_we && (host_addr == RI_CTL);
  assign start    = wr_ctl && cmd_valid(cmd) && !busy;
  assign reg_open = host_we && !busy;
  assign inc_fire = (ev_rok || ev_wok) && inc_q;

  assign m_axi_awprot = 3'b000;
  assign m_axi_arprot = 3'b000;
  assign m_axi_wstrb  = 4'hF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      addr_q   <= '0;
      wd_q     <= '0;
      rd_q     <= '0;
      inc_q    <= 1'b0;
      ravail_q <= 1'b0;
    end else begin
      if (wr_ctl) en_q <= host_wdata[EV_LO +: NEV];
      if (start) begin
        inc_q    <= cmd_incr(cmd);
        ravail_q <= 1'b0;
      end
      if (ev_rok) begin
        rd_q     <= m_axi_rdata;
        ravail_q <= 1'b1;
      end
      if (inc_fire) addr_q <= bump_addr(addr_q);
      if (reg_open) begin
        case (host_addr)
          RI_ADL: addr_q[HOST_W-1:0]      <= host_wdata;
          RI_ADH: addr_q[BUS_W-1:HOST_W]  <= host_wdata;
          RI_WDL: wd_q[HOST_W-1:0]        <= host_wdata;
          RI_WDH: wd_q[BUS_W-1:HOST_W]    <= host_wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_cnt <= '0;
      init_q   <= 1'b0;
    end else if (!init_q) begin
      if (init_cnt == IW'(INIT_CYCLES - 1)) init_q <= 1'b1;
      else                                  init_cnt <= init_cnt + IW'(1);
    end
  end

  axb_xfer #(.AW(BUS_W), .DW(BUS_W), .TIMEOUT(TIMEOUT)) u_xfer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .start_rd (cmd_is_read(cmd)),
    .addr_i   (addr_q),
    .wdata_i  (wd_q),
    .awaddr   (m_axi_awaddr),
    .awvalid  (m_axi_awvalid),
    .awready  (m_axi_awready),
    .wdata    (m_axi_wdata),
    .wvalid   (m_axi_wvalid),
    .wready   (m_axi_wready),
    .bresp    (m_axi_bresp),
    .bvalid   (m_axi_bvalid),
    .bready   (m_axi_bready),
    .araddr   (m_axi_araddr),
    .arvalid  (m_axi_arvalid),
    .arready  (m_axi_arready),
    .rresp    (m_axi_rresp),
    .rvalid   (m_axi_rvalid),
    .rready   (m_axi_rready),
    .busy     (busy),
    .ev_rok   (ev_rok),
    .ev_wok   (ev_wok),
    .ev_err   (ev_err),
    .ev_tmo   (ev_tmo)
  );

  always_comb begin
    ev_set           = '0;
    ev_set[EVI_XIRQ] = xirq_i;
    ev_set[EVI_ERR]  = ev_err;
    ev_set[EVI_TMO]  = ev_tmo;
    ev_set[EVI_WOK]  = ev_wok;
    ev_set[EVI_ROK]  = ev_rok;
  end

  assign ev_clr = wr_stat ? host_wdata[EV_LO +: NEV] : '0;

  axb_events #(.N(NEV)) u_events (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (ev_set),
    .en_i  (en_q),
    .clr_i (ev_clr),
    .st_o  (ev_st),
    .irq_o (irq_o)
  );

  always_comb begin
    stat_w                 = '0;
    stat_w[EV_LO +: NEV]   = ev_st;
    stat_w[SB_RAVAIL]      = ravail_q;
    stat_w[SB_BUSY]        = busy;
    stat_w[SB_INIT]        = init_q;
    case (host_addr)
      RI_STAT: host_rdata = stat_w;
      RI_CTL:  host_rdata = {en_q, {(HOST_W - NEV){1'b0}}};
      RI_ADL:  host_rdata = addr_q[HOST_W-1:0];
      RI_ADH:  host_rdata = addr_q[BUS_W-1:HOST_W];
      RI_WDL:  host_rdata = wd_q[HOST_W-1:0];
      RI_WDH:  host_rdata = wd_q[BUS_W-1:HOST_W];
      RI_RDL:  host_rdata = rd_q[HOST_W-1:0];
      default: host_rdata = rd_q[BUS_W-1:HOST_W];
    endcase
  end

  AST_POSTINC: assert property (@(posedge clk) disable iff (!rst_n)
    inc_fire |=> (addr_q == $past(addr_q) + 32'd4)); // R9
  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !inc_fire) |=> $stable(addr_q)); // R4
  AST_WDATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(wd_q)); // R4
endmodule

// File: tb/axb_bridge_tb.sv
module axb_bridge_tb;
  localparam int CLK_P = 10;
  localparam int TMO   = 256;
  localparam int INIT  = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [2:0]  host_addr = 3'd0;
  logic [15:0] host_wdata = 16'h0;
  logic [15:0] host_rdata;
  logic        xirq = 1'b0;
  logic        irq;
  logic [31:0] awaddr, wdata, araddr;
  logic [2:0]  awprot, arprot;
  logic        awvalid, wvalid, bready, arvalid, rready;
  logic [3:0]  wstrb;
  logic        awready = 1'b1, wready = 1'b1, arready = 1'b1;
  logic [1:0]  bresp = 2'b00, rresp = 2'b00;
  logic        bvalid = 1'b0, rvalid = 1'b0;
  logic [31:0] rdata = 32'h0;

  always #(CLK_P / 2) clk = ~clk;

  axb_bridge #(.TIMEOUT(TMO), .INIT_CYCLES(INIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .xirq_i(xirq), .irq_o(irq),
    .m_axi_awaddr(awaddr), .m_axi_awprot(awprot), .m_axi_awvalid(awvalid),
    .m_axi_awready(awready), .m_axi_wdata(wdata), .m_axi_wstrb(wstrb),
    .m_axi_wvalid(wvalid), .m_axi_wready(wready), .m_axi_bresp(bresp),
    .m_axi_bvalid(bvalid), .m_axi_bready(bready), .m_axi_araddr(araddr),
    .m_axi_arprot(arprot), .m_axi_arvalid(arvalid), .m_axi_arready(arready),
    .m_axi_rdata(rdata), .m_axi_rresp(rresp), .m_axi_rvalid(rvalid),
    .m_axi_rready(rready)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- slave model ----------------
  int s_lat = 0;
  bit s_mute = 0, s_flush = 0;
  logic [1:0] s_resp = 2'b00;
  bit got_aw = 0, got_w = 0, got_ar = 0, b_on = 0, r_on = 0;
  int lat = 0, n_aw = 0, n_w = 0, n_ar = 0;
  logic [31:0] cap_aw = 0, cap_wd = 0, cap_ar = 0;
  logic [3:0]  cap_st = 0;

  always @(posedge clk) begin
    if (s_flush) begin
      got_aw = 0; got_w = 0; got_ar = 0; b_on = 0; r_on = 0; lat = 0;
    end else begin
      if (bvalid && bready) begin b_on = 0; got_aw = 0; got_w = 0; lat = 0; end
      if (rvalid && rready) begin r_on = 0; got_ar = 0; lat = 0; end
      if (awvalid && awready) begin got_aw = 1; cap_aw = awaddr; n_aw++; end
      if (wvalid && wready) begin got_w = 1; cap_wd = wdata; cap_st = wstrb; n_w++; end
      if (arvalid && arready) begin got_ar = 1; cap_ar = araddr; n_ar++; end
      if (((got_aw && got_w) || got_ar) && !b_on && !r_on && !s_mute) begin
        if (lat >= s_lat) begin
          if (got_ar) r_on = 1; else b_on = 1;
        end else lat++;
      end
    end
  end

  always @(negedge clk) begin
    bvalid <= b_on;
    rvalid <= r_on;
    bresp  <= s_resp;
    rresp  <= s_resp;
    rdata  <= cap_ar ^ 32'h5A5A_C3C3;
  end

  // ---------------- reference model ----------------
  bit m_busy, m_isrd, m_inc, m_rda, m_init, wasb;
  int m_cnt, m_initc;
  logic [4:0]  m_en, m_st, m_ev, m_clr;
  logic [31:0] m_addr, m_wd, m_rd;
  logic [1:0]  m_code;
  logic [3:0]  m_cmd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_isrd = 0; m_inc = 0; m_rda = 0; m_init = 0;
      m_cnt = 0; m_initc = 0; m_en = 0; m_st = 0;
      m_addr = 0; m_wd = 0; m_rd = 0;
    end else begin
      wasb = m_busy;
      m_ev = 0;
      if (m_busy) begin
        m_code = m_isrd ? rresp : bresp;
        if (m_isrd ? (rvalid && rready) : (bvalid && bready)) begin
          if (m_code[1]) m_ev[1] = 1;
          else begin
            if (m_isrd) begin m_ev[4] = 1; m_rd = rdata; m_rda = 1; end
            else m_ev[3] = 1;
            if (m_inc) m_addr = m_addr + 4;
          end
          m_busy = 0;
        end else if (m_cnt == TMO - 1) begin
          m_ev[2] = 1; m_busy = 0;
        end else m_cnt++;
      end
      m_ev[0] = xirq;
      m_clr = (host_we && host_addr == 3'd0) ? host_wdata[15:11] : 5'd0;
      m_st = (m_st & ~m_clr) | (m_ev & m_en);
      if (host_we) begin
        m_cmd = host_wdata[3:0];
        case (host_addr)
          3'd1: begin
            m_en = host_wdata[15:11];
            if (!wasb && m_cmd >= 4'h8 && m_cmd <= 4'hB) begin
              m_busy = 1; m_cnt = 0; m_rda = 0;
              m_isrd = m_cmd[1]; m_inc = m_cmd[0];
            end
          end
          3'd2: if (!wasb) m_addr[15:0]  = host_wdata;
          3'd3: if (!wasb) m_addr[31:16] = host_wdata;
          3'd4: if (!wasb) m_wd[15:0]    = host_wdata;
          3'd5: if (!wasb) m_wd[31:16]   = host_wdata;
          default: ;
        endcase
      end
      if (!m_init) begin
        m_initc++;
        if (m_initc == INIT) m_init = 1;
      end
    end
  end

  function automatic logic [15:0] exp_reg(input logic [2:0] a);
    case (a)
      3'd0: return {m_st, 3'b000, m_rda, m_busy, m_init, 5'b00000};
      3'd1: return {m_en, 11'h0};
      3'd2: return m_addr[15:0];
      3'd3: return m_addr[31:16];
      3'd4: return m_wd[15:0];
      3'd5: return m_wd[31:16];
      3'd6: return m_rd[15:0];
      default: return m_rd[31:16];
    endcase
  endfunction

  // R12: interrupt output against the model on every clock
  always @(negedge clk) begin
    if (rst_n && !finished) chk("R12 irq per cycle", {31'b0, irq}, {31'b0, |(m_st & m_en)});
  end

  // ---------------- host tasks ----------------
  task automatic hw(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic chk_reg(input logic [2:0] a, input string tag);
    logic [15:0] d;
    rd_reg(a, d);
    chk(tag, {16'h0, d}, {16'h0, exp_reg(a)});
  endtask

  task automatic wait_idle();
    logic [15:0] d;
    for (int i = 0; i < 2000; i++) begin
      rd_reg(3'd0, d);
      if (!d[6]) break;
      @(negedge clk);
    end
  endtask

  task automatic flush_slave();
    @(negedge clk);
    s_flush = 1;
    @(negedge clk);
    s_flush = 0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int n, aw0, ar0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    rd_reg(3'd0, d);
    chk("R2 status after reset", {16'h0, d}, 32'h0);
    rd_reg(3'd1, d);
    chk("R2 control after reset", {16'h0, d}, 32'h0);
    chk("R2 irq after reset", {31'b0, irq}, 32'h0);
    // init done after INIT edges
    repeat (INIT - 1) @(negedge clk);
    rd_reg(3'd0, d);
    chk("R2 init not yet", {31'b0, d[5]}, 32'h0);
    @(negedge clk);
    rd_reg(3'd0, d);
    chk("R2 init done", {31'b0, d[5]}, 32'h1);

    // R1 enables readback, address/data halves
    hw(3'd1, 16'hF800);
    rd_reg(3'd1, d);
    chk("R1 control readback", {16'h0, d}, 32'h0000_F800);
    hw(3'd2, 16'h1000); hw(3'd3, 16'hABCD);
    hw(3'd4, 16'hBEEF); hw(3'd5, 16'hDEAD);
    chk_reg(3'd3, "R1 addr high");
    chk_reg(3'd5, "R1 wdata high");

    // R5 write transfer
    s_lat = 2; s_resp = 2'b00;
    hw(3'd1, 16'hF808);
    rd_reg(3'd0, d);
    chk("R4 busy after command", {31'b0, d[6]}, 32'h1);
    wait_idle();
    chk("R5 one AW", n_aw, 1);
    chk("R5 one W", n_w, 1);
    chk("R5 awaddr", cap_aw, 32'hABCD_1000);
    chk("R5 wdata", cap_wd, 32'hDEAD_BEEF);
    chk("R5 wstrb", {28'h0, cap_st}, 32'hF);
    chk("R5 prot", {26'h0, awprot, arprot}, 32'h0);
    rd_reg(3'd0, d);
    chk("R7 write complete", {16'h0, d & 16'hF8C0}, 32'h4000);
    chk("R12 irq set", {31'b0, irq}, 32'h1);
    chk_reg(3'd2, "R9 no inc on plain write");
    hw(3'd0, 16'hF800);
    rd_reg(3'd0, d);
    chk("R10 W1C clear", {16'h0, d & 16'hF800}, 32'h0);

    // R6 / R9 read with increment and carry
    hw(3'd2, 16'hFFFC); hw(3'd3, 16'h0000);
    s_lat = 0;
    hw(3'd1, 16'hF80B);
    wait_idle();
    rd_reg(3'd6, d);
    chk("R6 read low", {16'h0, d}, 32'h0000_3C3F);
    rd_reg(3'd7, d);
    chk("R6 read high", {16'h0, d}, 32'h0000_5A5A);
    chk("R6 araddr", cap_ar, 32'h0000_FFFC);
    rd_reg(3'd0, d);
    chk("R6 read done and available", {16'h0, d & 16'hF8C0}, 32'h8080);
    rd_reg(3'd2, d);
    chk("R9 inc low", {16'h0, d}, 32'h0);
    rd_reg(3'd3, d);
    chk("R9 inc carry high", {16'h0, d}, 32'h1);
    hw(3'd1, 16'h0000);
    chk("R12 irq off when disabled", {31'b0, irq}, 32'h0);
    hw(3'd1, 16'hF800);
    hw(3'd0, 16'hF800);

    // R7 error response on write-increment
    s_resp = 2'b10;
    hw(3'd1, 16'hF809);
    rd_reg(3'd0, d);
    chk("R6 avail cleared at start", {31'b0, d[7]}, 32'h0);
    wait_idle();
    rd_reg(3'd0, d);
    chk("R7 slverr gives error only", {16'h0, d & 16'hF800}, 32'h1000);
    chk_reg(3'd2, "R9 no inc after error");
    rd_reg(3'd3, d);
    chk("R9 addr high kept", {16'h0, d}, 32'h1);
    hw(3'd0, 16'hF800);
    s_resp = 2'b11;
    hw(3'd1, 16'hF80A);
    wait_idle();
    rd_reg(3'd0, d);
    chk("R7 decerr read", {16'h0, d & 16'hF800}, 32'h1000);
    hw(3'd0, 16'hF800);
    s_resp = 2'b00;

    // R8 timeout
    s_mute = 1;
    hw(3'd1, 16'hF80A);
    n = 0;
    for (int i = 0; i < 2 * TMO; i++) begin
      rd_reg(3'd0, d);
      if (!d[6]) break;
      n++;
      @(negedge clk);
    end
    chk("R8 busy length", n, TMO);
    rd_reg(3'd0, d);
    chk("R8 timeout event", {16'h0, d & 16'hF800}, 32'h2000);
    chk("R8 valids dropped", {30'h0, arvalid, awvalid}, 32'h0);
    s_mute = 0;
    flush_slave();
    hw(3'd0, 16'hF800);

    // R4 ignore command and address writes while busy
    s_lat = 30;
    aw0 = n_aw;
    hw(3'd1, 16'hF80A);
    hw(3'd1, 16'hF808);
    hw(3'd2, 16'h5555);
    hw(3'd5, 16'h7777);
    wait_idle();
    chk("R4 no write while busy", n_aw, aw0);
    chk_reg(3'd2, "R4 addr write ignored");
    chk_reg(3'd5, "R4 wdata write ignored");
    rd_reg(3'd0, d);
    chk("R4 only read completed", {16'h0, d & 16'hF800}, 32'h8000);
    hw(3'd0, 16'hF800);
    s_lat = 0;

    // R3 invalid codes
    aw0 = n_aw; ar0 = n_ar;
    hw(3'd1, 16'hF803);
    hw(3'd1, 16'hF80C);
    repeat (4) @(negedge clk);
    chk("R3 invalid code no transfer", n_aw + n_ar, aw0 + ar0);
    rd_reg(3'd0, d);
    chk("R3 invalid code not busy", {31'b0, d[6]}, 32'h0);

    // R10 enable gating
    hw(3'd1, 16'h8008);
    wait_idle();
    rd_reg(3'd0, d);
    chk("R10 disabled event not recorded", {16'h0, d & 16'hF800}, 32'h0);
    chk("R10 irq stays low", {31'b0, irq}, 32'h0);

    // R11 external interrupt and set-over-clear
    hw(3'd1, 16'h0800);
    @(negedge clk); xirq = 1;
    @(negedge clk);
    rd_reg(3'd0, d);
    chk("R11 xirq event", {31'b0, d[11]}, 32'h1);
    chk("R12 irq from xirq", {31'b0, irq}, 32'h1);
    hw(3'd0, 16'h0800);
    rd_reg(3'd0, d);
    chk("R10 set wins over clear", {31'b0, d[11]}, 32'h1);
    xirq = 0;
    @(negedge clk);
    hw(3'd0, 16'h0800);
    rd_reg(3'd0, d);
    chk("R10 cleared after input low", {31'b0, d[11]}, 32'h0);
    for (int a = 0; a < 8; a++) chk_reg(3'(a), "R1 final register image");

    finished = 1;
    report();
    $finish;
  end
endmodule